// File: doc/BRIEF.md
# Millisecond Pacer Timer

This block produces a periodic trigger tick for a scan sequencer. The period is a whole number of milliseconds, between 1 and 1024. A clock-cycles-per-millisecond prescaler divides the system clock into millisecond steps. A period counter then divides those steps by the programmed count and emits a one-cycle tick at the end of each period.

The 10-bit period count is loaded in two register writes.

- A write to the upper part only stages the top bits.
- A write to the lower part commits the whole value, built from the staged upper bits and the new lower byte.
- A committed value of zero selects the longest period, 1024 ms. It does not stop the timer.

Every commit restarts the prescaler and the period counter, so the first tick of the new period comes one full new period after the commit. Ticks are produced only while the enable input (pacer mode selected) is high. Dropping the enable clears both counters, so enabling again starts a fresh full period.

A two-state machine controls the timer.

- `PT_IDLE`: the counters are held at zero and no tick is produced.
- `PT_RUN`: the counters advance.
- Transition GO (`PT_IDLE` to `PT_RUN`): taken on the first clock edge with the enable high.
- Transition STOP (`PT_RUN` to `PT_IDLE`): taken on an edge with the enable low.
- Self-loop RELOAD (in `PT_RUN`): a lower-part write clears both counters without leaving the state.
- Self-loop HOLD (in `PT_IDLE`): taken while the enable stays low.

`CYC_PER_MS` must be at least 2.

Top module: `pacer_timer`

## Requirements
- R1: After reset the tick output is low and the active period count is zero, so the first period after enabling is 1024 ms.
- R2: For a committed count n from 1 to 1023, consecutive ticks are n*CYC_PER_MS clock cycles apart.
- R3: A committed count of 0 gives ticks 1024*CYC_PER_MS clock cycles apart.
- R4: A write on `hi_wr` only stages the upper bits and leaves the running period unchanged. A write on `lo_wr` sets the active count to {staged upper bits, lo_data}. The staged upper bits persist across later lower-part writes.
- R5: The clock edge that samples `lo_wr` high restarts timing. The next tick is seen in the cycle that follows the edge exactly P cycles later, where P is the new period in cycles. This holds even when the old period would have ended on that same edge.
- R6: Each tick is high for exactly one clock cycle.
- R7: While `pace_en` is low, no tick is produced. After `pace_en` rises, the first tick follows the first edge that samples it high by exactly one full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pace_en | input | 1 | High while pacer mode is the selected trigger source |
| hi_wr | input | 1 | Strobe that stages the upper period bits |
| hi_data | input | PERIOD_W-BYTE_W | Upper period bits (2 by default) |
| lo_wr | input | 1 | Strobe that commits the period with the lower byte |
| lo_data | input | BYTE_W | Lower period byte |
| tick | output | 1 | One-cycle periodic trigger |

## Verification
The two functions that can fall in the same cycle are a commit of a new period and the natural end of the old one. To provoke this, the bench first synchronises to a tick of a 1 ms period. It then times a lower-part write so that the edge sampling the write is the same edge on which the old period would have expired. The collision is judged correct when no tick appears in the following cycle and the next tick arrives exactly one new period after that edge.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    // Control states of the pacer timer
    typedef enum logic [0:0] {
        PT_IDLE = 1'b0,   // counters held at zero, no tick
        PT_RUN  = 1'b1    // prescaler and period counter advancing
    } pt_state_e;

    // Width helper that never returns zero
    function automatic int unsigned safe_clog2(input int unsigned value);
        return (value > 1) ? $clog2(value) : 1;
    endfunction

endpackage

// File: rtl/pacer_period_reg.sv
module pacer_period_reg #(
    parameter int unsigned PERIOD_W = 10,
    parameter int unsigned BYTE_W   = 8,
    localparam int unsigned HI_W    = PERIOD_W - BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hi_wr,
    input  logic [HI_W-1:0]     hi_data,
    input  logic                lo_wr,
    input  logic [BYTE_W-1:0]   lo_data,
    output logic [PERIOD_W-1:0] period_o,
    output logic                commit_o
);

    logic [HI_W-1:0] stage_hi;

    // Upper bits wait here until the lower-part write arrives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_hi <= '0;
        end else if (hi_wr) begin
            stage_hi <= hi_data;
        end
    end

    // Active period changes only on a lower-part write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_o <= '0;
        end else if (lo_wr) begin
            period_o <= {stage_hi, lo_data};
        end
    end

    assign commit_o = lo_wr;

    // R4: nothing but the lower-part write may move the active period
    assert_stage_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_wr |=> $stable(period_o));

endmodule

// File: rtl/pacer_prescaler.sv
module pacer_prescaler import pacer_pkg::*; #(
    parameter int unsigned CYC_PER_MS = 50000,
    localparam int unsigned PRE_W     = safe_clog2(CYC_PER_MS),
    localparam logic [PRE_W-1:0] LAST = PRE_W'(CYC_PER_MS - 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic ms_pulse
);

    logic [PRE_W-1:0] pre_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (clear) begin
            pre_cnt <= '0;
        end else if (pre_cnt == LAST) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assign ms_pulse = !clear && (pre_cnt == LAST);

    // R2: millisecond steps are never back to back (CYC_PER_MS >= 2)
    assert_ms_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ms_pulse |=> !ms_pulse);

endmodule

// File: rtl/pacer_ms_counter.sv
module pacer_ms_counter #(
    parameter int unsigned PERIOD_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                ms_pulse,
    input  logic [PERIOD_W-1:0] period,
    output logic                wrap
);

    logic [PERIOD_W-1:0] ms_cnt;
    logic [PERIOD_W-1:0] term;

    // Zero selects the full 2**PERIOD_W count
    always_comb begin
        if (period == '0) begin
            term = '1;
        end else begin
            term = period - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_cnt <= '0;
        end else if (clear) begin
            ms_cnt <= '0;
        end else if (ms_pulse) begin
            if (ms_cnt == term) begin
                ms_cnt <= '0;
            end else begin
                ms_cnt <= ms_cnt + 1'b1;
            end
        end
    end

    assign wrap = ms_pulse && (ms_cnt == term);

    // R2: the count never passes the terminal value of the active period
    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (ms_cnt <= term));

endmodule

// File: rtl/pacer_timer.sv
module pacer_timer import pacer_pkg::*; #(
    parameter int unsigned CYC_PER_MS = 50000,
    parameter int unsigned PERIOD_W   = 10,
    parameter int unsigned BYTE_W     = 8,
    localparam int unsigned HI_W      = PERIOD_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pace_en,
    input  logic              hi_wr,
    input  logic [HI_W-1:0]   hi_data,
    input  logic              lo_wr,
    input  logic [BYTE_W-1:0] lo_data,
    output logic              tick
);

    pt_state_e           state_q;
    pt_state_e           state_d;
    logic [PERIOD_W-1:0] period;
    logic                commit;
    logic                clear;
    logic                ms_pulse;
    logic                wrap;

    pacer_period_reg #(
        .PERIOD_W (PERIOD_W),
        .BYTE_W   (BYTE_W)
    ) i_period_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_wr    (hi_wr),
        .hi_data  (hi_data),
        .lo_wr    (lo_wr),
        .lo_data  (lo_data),
        .period_o (period),
        .commit_o (commit)
    );

    // Counters are cleared outside PT_RUN, on STOP and on RELOAD
    assign clear = (state_q != PT_RUN) || !pace_en || commit;

    pacer_prescaler #(
        .CYC_PER_MS (CYC_PER_MS)
    ) i_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .ms_pulse (ms_pulse)
    );

    pacer_ms_counter #(
        .PERIOD_W (PERIOD_W)
    ) i_ms_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .ms_pulse (ms_pulse),
        .period   (period),
        .wrap     (wrap)
    );

    // Next-state logic: GO, STOP, HOLD, RELOAD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PT_IDLE: if (pace_en)  state_d = PT_RUN;
            PT_RUN:  if (!pace_en) state_d = PT_IDLE;
            default: state_d = PT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered tick output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= 1'b0;
        end else begin
            unique case (state_q)
                PT_IDLE: tick <= 1'b0;
                PT_RUN:  tick <= !clear && wrap;
                default: tick <= 1'b0;
            endcase
        end
    end

    // R6: a tick never lasts two cycles
    assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R7: no tick follows an edge that sees the enable low
    assert_off_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pace_en |=> !tick);

    // R5: a commit edge wins over an expiring old period
    assert_commit_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> !tick);

endmodule

// File: tb/test_pacer_timer.sv
module test_pacer_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pace_en = 1'b0;
    logic       hi_wr = 1'b0;
    logic [1:0] hi_data = '0;
    logic       lo_wr = 1'b0;
    logic [7:0] lo_data = '0;
    logic       tick;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pacer_timer #(
        .CYC_PER_MS (CPM)
    ) i_pacer_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .pace_en (pace_en),
        .hi_wr   (hi_wr),
        .hi_data (hi_data),
        .lo_wr   (lo_wr),
        .lo_data (lo_data),
        .tick    (tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Counts rising edges until a tick is seen; -1 on timeout
    task automatic count_to_tick(output int k, input int limit);
        k = 0;
        forever begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (tick) break;
            if (k >= limit) begin
                k = -1;
                break;
            end
        end
    endtask

    task automatic hi_write(input logic [1:0] d);
        @(negedge clk);
        hi_wr = 1'b1;
        hi_data = d;
        @(posedge clk);
        #1 hi_wr = 1'b0;
    endtask

    task automatic lo_write(input logic [7:0] d);
        @(negedge clk);
        lo_wr = 1'b1;
        lo_data = d;
        @(posedge clk);
        #1 lo_wr = 1'b0;
    endtask

    function automatic int cycles_of(input int n);
        return (n == 0) ? 1024 * CPM : n * CPM;
    endfunction

    task automatic t_reset();
        int seen;
        seen = 0;
        @(negedge clk);
        check(tick == 1'b0, "R1 tick low in reset", int'(tick), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick) seen++;
        end
        check(seen == 0, "R7 no tick while disabled", seen, 0);
    endtask

    task automatic t_default();
        int k;
        @(negedge clk);
        pace_en = 1'b1;
        @(posedge clk);
        #1;
        count_to_tick(k, cycles_of(0) + 10);
        check(k == cycles_of(0), "R1 R3 default period after reset", k, cycles_of(0));
        @(negedge clk);
        check(tick == 1'b0, "R6 tick one cycle wide", int'(tick), 0);
    endtask

    task automatic t_period(input logic [1:0] h, input logic [7:0] l, input string req);
        int k;
        int n;
        n = {h, l};
        hi_write(h);
        lo_write(l);
        count_to_tick(k, cycles_of(n) + 10);
        check(k == cycles_of(n), {req, " R5 first tick after commit"}, k, cycles_of(n));
        count_to_tick(k, cycles_of(n) + 10);
        check(k == cycles_of(n), {req, " steady spacing"}, k, cycles_of(n));
        @(negedge clk);
        check(tick == 1'b0, "R6 tick falls after one cycle", int'(tick), 0);
    endtask

    task automatic t_stage();
        int k;
        t_period(2'd0, 8'd1, "R2 min period");
        hi_write(2'd2);
        count_to_tick(k, 100);
        count_to_tick(k, 100);
        check(k == cycles_of(1), "R4 upper write alone ignored", k, cycles_of(1));
        // commit edge lands on the edge where the old period expires
        repeat (3) @(posedge clk);
        lo_write(8'd1);
        @(negedge clk);
        check(tick == 1'b0, "R5 commit suppresses expiring tick", int'(tick), 0);
        count_to_tick(k, cycles_of(513) + 10);
        check(k == cycles_of(513), "R4 R5 staged upper bits committed", k, cycles_of(513));
        lo_write(8'd2);
        count_to_tick(k, cycles_of(514) + 10);
        check(k == cycles_of(514), "R4 staged bits persist", k, cycles_of(514));
    endtask

    task automatic t_disable();
        int k;
        int seen;
        seen = 0;
        hi_write(2'd0);
        lo_write(8'd3);
        repeat (5) @(posedge clk);
        @(negedge clk);
        pace_en = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick) seen++;
        end
        check(seen == 0, "R7 silent when disabled", seen, 0);
        @(negedge clk);
        pace_en = 1'b1;
        @(posedge clk);
        #1;
        count_to_tick(k, cycles_of(3) + 10);
        check(k == cycles_of(3), "R7 fresh period on enable", k, cycles_of(3));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_default();
        t_period(2'd0, 8'd3, "R2 period 3");
        t_stage();
        t_disable();
        t_period(2'd3, 8'hFF, "R2 max count");
        t_period(2'd0, 8'd0, "R3 zero count");
        summary();
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R5 run hung actual 0 expected 1");
        summary();
        $finish;
    end

endmodule